// File: doc/BRIEF.md
# Branch and Skip Resolution Unit

This block resolves control flow for a small core with 16-bit instruction words. It receives one flow-control instruction together with the operands that decide its outcome. It returns the program counter of the next instruction to fetch, whether the flow was redirected, and how many cycles the instruction occupies. The operands are the current PC, a signed displacement, the 16-bit Z pointer, the status byte, the two compared bytes, an I/O byte and the bit select. Call and return stack handling lives elsewhere.

The instruction class picks one of six behaviours:
- a relative jump;
- an indirect jump through Z;
- a conditional branch on one status bit, either set or clear;
- a skip when two registers are equal;
- a skip on a register bit;
- a skip on an I/O bit.

A taken skip must step over the whole following instruction. For that reason the decoder also tells the unit whether the next instruction is one word or two, and the cycle count follows. The result is registered: it appears on the cycle after the request and is held until the next request.

Top module: `branch_skip_unit`

## Requirements
- R1: After reset, out_valid, taken, next_pc and cycles are all 0.
- R2: A request with in_valid high gives its result and out_valid=1 one clock later. While in_valid is low, out_valid is 0 and next_pc, taken and cycles hold their last values.
- R3: Class 1 (relative jump) gives next_pc = pc + sign-extended disp[11:0] + 1, taken=1 and cycles=2.
- R4: Class 2 (indirect jump) gives next_pc = zptr[PC_W-1:0], taken=1 and cycles=2.
- R5: Class 3 (branch) tests status bit sel against pol. The bit order is C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. A match gives next_pc = pc + sign-extended disp[6:0] + 1, taken=1 and cycles=2. A mismatch gives pc + 1, taken=0 and cycles=1.
- R6: For a branch on bit 4, the tested value is N XOR V, computed from sreg[2] and sreg[3]. The stored sreg[4] is not used. With pol=0 this is the signed greater-or-equal test; with pol=1 it is the signed less-than test.
- R7: Class 4 skips when opa equals opb.
- R8: Class 5 skips when opa[sel] equals pol, with pol=1 meaning skip if set.
- R9: Class 6 skips when io_byte[sel] equals pol.
- R10: A taken skip gives next_pc = pc + 2 and cycles=2 when next_two_word=0, and pc + 3 and cycles=3 when next_two_word=1. A skip not taken gives pc + 1 and cycles=1.
- R11: All PC arithmetic wraps modulo 2^PC_W words.
- R12: Class 0 (sequential) and the reserved class 7 give next_pc = pc + 1, taken=0 and cycles=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op_class | input | 3 | Instruction class, 0..7 |
| pc | input | PC_W | Current program counter in words |
| disp | input | 12 | Signed word displacement; bits 6:0 for branches |
| zptr | input | 16 | Z pointer for the indirect jump |
| sreg | input | 8 | Status byte |
| sel | input | 3 | Bit select for branches and bit skips |
| pol | input | 1 | 1 = condition on bit set, 0 = on bit clear |
| opa | input | 8 | First compared register / tested register |
| opb | input | 8 | Second compared register |
| io_byte | input | 8 | Tested I/O register |
| next_two_word | input | 1 | Next instruction is two words long |
| out_valid | output | 1 | Result valid |
| next_pc | output | PC_W | Resolved next program counter |
| taken | output | 1 | Flow redirected or skip taken |
| cycles | output | 2 | Instruction cycle count, 1..3 |

## Verification
The unit holds only its output register, so any fault in condition evaluation, target arithmetic or the cycle table shows up at next_pc, taken or cycles on the very cycle after the request. A wrong condition bit produces two visible errors together: the taken flag flips, and both the PC and the cycle count move to the other column. A wrong choice of skip length gives a PC off by exactly one and a cycle count of 2 where 3 is expected, or the reverse. A hold fault shows as next_pc changing while in_valid is low.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [2:0] {
    CLS_SEQ       = 3'd0,
    CLS_RELJMP    = 3'd1,
    CLS_INDJMP    = 3'd2,
    CLS_BRANCH    = 3'd3,
    CLS_SKIP_EQ   = 3'd4,
    CLS_SKIP_RBIT = 3'd5,
    CLS_SKIP_IO   = 3'd6,
    CLS_RSVD      = 3'd7
  } op_class_e;

  localparam int FLAG_N = 2;
  localparam int FLAG_V = 3;
  localparam int FLAG_S = 4;

  // Sign-extend the low w bits of raw to 16 bits.
  function automatic logic [15:0] sext16(input logic [15:0] raw, input int w);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) begin
      r[i] = (i < w) ? raw[i] : raw[w-1];
    end
    return r;
  endfunction

  // Word-address advance; the caller truncates to the PC width.
  function automatic logic [15:0] pc_advance(input logic [15:0] base,
                                             input logic [15:0] delta);
    return base + delta;
  endfunction

endpackage

// File: rtl/bsr_cond_eval.sv
module bsr_cond_eval
  import bsr_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int SEL_W          = $clog2(DATA_W),
  parameter bit SIGNED_FROM_NV = 1'b1
) (
  input  op_class_e          cls,
  input  logic [7:0]         sreg,
  input  logic [SEL_W-1:0]   sel,
  input  logic               pol,
  input  logic [DATA_W-1:0]  opa,
  input  logic [DATA_W-1:0]  opb,
  input  logic [DATA_W-1:0]  io_byte,
  output logic               cond_hit
);

  logic       sign_flag;
  logic [7:0] eff_sreg;
  logic       status_bit;
  logic       reg_bit;
  logic       io_bit;

  generate
    if (SIGNED_FROM_NV) begin : g_sign_nv
      assign sign_flag = sreg[FLAG_N] ^ sreg[FLAG_V];
    end else begin : g_sign_stored
      assign sign_flag = sreg[FLAG_S];
    end
  endgenerate

  always_comb begin
    eff_sreg         = sreg;
    eff_sreg[FLAG_S] = sign_flag;
    status_bit       = eff_sreg[sel];
    reg_bit          = opa[sel];
    io_bit           = io_byte[sel];
    case (cls)
      CLS_BRANCH:    cond_hit = (status_bit == pol);
      CLS_SKIP_EQ:   cond_hit = (opa == opb);
      CLS_SKIP_RBIT: cond_hit = (reg_bit == pol);
      CLS_SKIP_IO:   cond_hit = (io_bit == pol);
      default:       cond_hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/bsr_target_calc.sv
module bsr_target_calc
  import bsr_pkg::*;
#(
  parameter int PC_W      = 10,
  parameter int DISP_W    = 12,
  parameter int BR_DISP_W = 7
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  input  logic [15:0]       zptr,
  output logic [PC_W-1:0]   seq_pc,
  output logic [PC_W-1:0]   skip1_pc,
  output logic [PC_W-1:0]   skip2_pc,
  output logic [PC_W-1:0]   rel_pc,
  output logic [PC_W-1:0]   br_pc,
  output logic [PC_W-1:0]   ind_pc
);

  logic [15:0] pc16;
  logic [15:0] rel_off;
  logic [15:0] br_off;
  logic [15:0] rel_sum;
  logic [15:0] br_sum;

  assign pc16    = 16'(pc);
  assign rel_off = sext16(16'(disp), DISP_W);
  assign br_off  = sext16(16'(disp), BR_DISP_W);
  assign rel_sum = pc_advance(pc_advance(pc16, rel_off), 16'd1);
  assign br_sum  = pc_advance(pc_advance(pc16, br_off), 16'd1);

  assign seq_pc   = PC_W'(pc_advance(pc16, 16'd1));
  assign skip1_pc = PC_W'(pc_advance(pc16, 16'd2));
  assign skip2_pc = PC_W'(pc_advance(pc16, 16'd3));
  assign rel_pc   = PC_W'(rel_sum);
  assign br_pc    = PC_W'(br_sum);
  assign ind_pc   = zptr[PC_W-1:0];

endmodule

// File: rtl/bsr_resolve.sv
module bsr_resolve
  import bsr_pkg::*;
#(
  parameter int PC_W = 10
) (
  input  op_class_e        cls,
  input  logic             cond_hit,
  input  logic             two_word,
  input  logic [PC_W-1:0]  seq_pc,
  input  logic [PC_W-1:0]  skip1_pc,
  input  logic [PC_W-1:0]  skip2_pc,
  input  logic [PC_W-1:0]  rel_pc,
  input  logic [PC_W-1:0]  br_pc,
  input  logic [PC_W-1:0]  ind_pc,
  output logic [PC_W-1:0]  nxt_pc,
  output logic             nxt_taken,
  output logic [1:0]       nxt_cycles
);

  always_comb begin
    nxt_pc     = seq_pc;
    nxt_taken  = 1'b0;
    nxt_cycles = 2'd1;
    case (cls)
      CLS_RELJMP: begin
        nxt_pc     = rel_pc;
        nxt_taken  = 1'b1;
        nxt_cycles = 2'd2;
      end
      CLS_INDJMP: begin
        nxt_pc     = ind_pc;
        nxt_taken  = 1'b1;
        nxt_cycles = 2'd2;
      end
      CLS_BRANCH: begin
        if (cond_hit) begin
          nxt_pc     = br_pc;
          nxt_taken  = 1'b1;
          nxt_cycles = 2'd2;
        end
      end
      CLS_SKIP_EQ, CLS_SKIP_RBIT, CLS_SKIP_IO: begin
        if (cond_hit) begin
          nxt_taken  = 1'b1;
          nxt_pc     = two_word ? skip2_pc : skip1_pc;
          nxt_cycles = two_word ? 2'd3 : 2'd2;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/branch_skip_unit.sv
module branch_skip_unit
  import bsr_pkg::*;
#(
  parameter int PC_W           = 10,
  parameter int DATA_W         = 8,
  parameter int DISP_W         = 12,
  parameter int BR_DISP_W      = 7,
  parameter bit SIGNED_FROM_NV = 1'b1,
  localparam int SEL_W         = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op_class,
  input  logic [PC_W-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  input  logic [15:0]       zptr,
  input  logic [7:0]        sreg,
  input  logic [SEL_W-1:0]  sel,
  input  logic              pol,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] io_byte,
  input  logic              next_two_word,
  output logic              out_valid,
  output logic [PC_W-1:0]   next_pc,
  output logic              taken,
  output logic [1:0]        cycles
);

  op_class_e       cls;
  logic            cond_hit;
  logic [PC_W-1:0] seq_pc, skip1_pc, skip2_pc, rel_pc, br_pc, ind_pc;
  logic [PC_W-1:0] nxt_pc;
  logic            nxt_taken;
  logic [1:0]      nxt_cycles;

  assign cls = op_class_e'(op_class);

  bsr_cond_eval #(
    .DATA_W(DATA_W), .SEL_W(SEL_W), .SIGNED_FROM_NV(SIGNED_FROM_NV)
  ) u_cond (
    .cls(cls), .sreg(sreg), .sel(sel), .pol(pol),
    .opa(opa), .opb(opb), .io_byte(io_byte), .cond_hit(cond_hit)
  );

  bsr_target_calc #(
    .PC_W(PC_W), .DISP_W(DISP_W), .BR_DISP_W(BR_DISP_W)
  ) u_tgt (
    .pc(pc), .disp(disp), .zptr(zptr),
    .seq_pc(seq_pc), .skip1_pc(skip1_pc), .skip2_pc(skip2_pc),
    .rel_pc(rel_pc), .br_pc(br_pc), .ind_pc(ind_pc)
  );

  bsr_resolve #(.PC_W(PC_W)) u_res (
    .cls(cls), .cond_hit(cond_hit), .two_word(next_two_word),
    .seq_pc(seq_pc), .skip1_pc(skip1_pc), .skip2_pc(skip2_pc),
    .rel_pc(rel_pc), .br_pc(br_pc), .ind_pc(ind_pc),
    .nxt_pc(nxt_pc), .nxt_taken(nxt_taken), .nxt_cycles(nxt_cycles)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      next_pc   <= '0;
      taken     <= 1'b0;
      cycles    <= 2'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        next_pc <= nxt_pc;
        taken   <= nxt_taken;
        cycles  <= nxt_cycles;
      end
    end
  end

endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
  parameter int PC_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [2:0]      op_class,
  input logic [PC_W-1:0] pc,
  input logic            next_two_word,
  input logic            cond_hit,
  input logic            out_valid,
  input logic [PC_W-1:0] next_pc,
  input logic            taken,
  input logic [1:0]      cycles
);

  logic [PC_W-1:0] pc_plus1;
  logic            is_jump, is_seq, is_skip;

  assign pc_plus1 = pc + PC_W'(1);
  assign is_jump  = (op_class == 3'd1) || (op_class == 3'd2);
  assign is_seq   = (op_class == 3'd0) || (op_class == 3'd7);
  assign is_skip  = (op_class >= 3'd4) && (op_class <= 3'd6);

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(next_pc) && $stable(taken) && $stable(cycles)));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_jump_two_cycles_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_jump) |=> (taken && cycles == 2'd2));

  assert_not_taken_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (taken || (next_pc == $past(pc_plus1) && cycles == 2'd1)));

  assert_skip_length_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_skip && cond_hit) |=>
      (taken && cycles == ($past(next_two_word) ? 2'd3 : 2'd2)));

  assert_seq_class_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_seq) |=> (!taken && cycles == 2'd1));

  assert_cycle_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (cycles != 2'd0));

endmodule

bind branch_skip_unit bsr_checker #(.PC_W(PC_W)) u_bsr_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_class(op_class),
  .pc(pc), .next_two_word(next_two_word), .cond_hit(cond_hit),
  .out_valid(out_valid), .next_pc(next_pc), .taken(taken), .cycles(cycles)
);

// File: tb/tb_branch_skip_unit.sv
`timescale 1ns/1ps
module tb_branch_skip_unit;

  localparam int PC_W = 10;
  localparam int MASK = (1 << PC_W) - 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [2:0]      op_class = '0;
  logic [PC_W-1:0] pc = '0;
  logic [11:0]     disp = '0;
  logic [15:0]     zptr = '0;
  logic [7:0]      sreg = '0;
  logic [2:0]      sel = '0;
  logic            pol = 1'b0;
  logic [7:0]      opa = '0, opb = '0, io_byte = '0;
  logic            next_two_word = 1'b0;
  logic            out_valid;
  logic [PC_W-1:0] next_pc;
  logic            taken;
  logic [1:0]      cycles;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  branch_skip_unit #(.PC_W(PC_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_class(op_class),
    .pc(pc), .disp(disp), .zptr(zptr), .sreg(sreg), .sel(sel), .pol(pol),
    .opa(opa), .opb(opb), .io_byte(io_byte), .next_two_word(next_two_word),
    .out_valid(out_valid), .next_pc(next_pc), .taken(taken), .cycles(cycles)
  );

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic expect_out(string req, bit exp_v, int exp_pc, bit exp_tk, int exp_cy);
    n_cmp++;
    if (out_valid !== exp_v || next_pc !== PC_W'(exp_pc & MASK) ||
        taken !== exp_tk || cycles !== 2'(exp_cy)) begin
      n_bad++;
      $display("FAIL %s: got v=%0b pc=%0d tk=%0b cy=%0d, expected v=%0b pc=%0d tk=%0b cy=%0d",
               req, out_valid, next_pc, taken, cycles, exp_v, exp_pc & MASK, exp_tk, exp_cy);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge with the result registered.
  task automatic issue(input logic [2:0] c, input int p);
    op_class = c;
    pc       = PC_W'(p);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset_R1;
    expect_out("R1 reset", 1'b0, 0, 1'b0, 0);
  endtask

  task automatic t_reljmp_R3;
    disp = 12'd20;         issue(3'd1, 100); expect_out("R3 forward", 1, 121, 1, 2);
    disp = 12'hFFF;        issue(3'd1, 100); expect_out("R3 minus one", 1, 100, 1, 2);
    disp = 12'h800;        issue(3'd1, 900); expect_out("R3 most negative R11", 1, 900 - 2048 + 1, 1, 2);
  endtask

  task automatic t_indjmp_R4;
    zptr = 16'hABCD; issue(3'd2, 7); expect_out("R4 indirect", 1, 16'hABCD, 1, 2);
  endtask

  task automatic t_branch_R5;
    sreg = 8'b0000_0010; sel = 3'd1; disp = 12'h07E; pol = 1'b1;
    issue(3'd3, 50); expect_out("R5 Z set taken back", 1, 49, 1, 2);
    pol = 1'b0;
    issue(3'd3, 50); expect_out("R5 Z clear not taken", 1, 51, 0, 1);
    sel = 3'd0; pol = 1'b0; disp = 12'hF05;  // C clear, upper bits of disp ignored
    issue(3'd3, 50); expect_out("R5 C clear taken", 1, 56, 1, 2);
    disp = 12'h040;                           // -64
    issue(3'd3, 30); expect_out("R5 wrap R11", 1, 30 - 64 + 1, 1, 2);
  endtask

  task automatic t_signed_R6;
    sreg = 8'b0000_0100; sel = 3'd4; disp = 12'd3; pol = 1'b1;
    issue(3'd3, 10); expect_out("R6 less-than N^V=1", 1, 14, 1, 2);
    pol = 1'b0;
    issue(3'd3, 10); expect_out("R6 ge not taken", 1, 11, 0, 1);
    sreg = 8'b0001_1100;
    issue(3'd3, 10); expect_out("R6 ge N^V=0 stored S=1", 1, 14, 1, 2);
  endtask

  task automatic t_skip_eq_R7;
    opa = 8'h5A; opb = 8'h5A; next_two_word = 1'b0;
    issue(3'd4, 200); expect_out("R7 equal one-word R10", 1, 202, 1, 2);
    opb = 8'h5B;
    issue(3'd4, 200); expect_out("R7 differ", 1, 201, 0, 1);
  endtask

  task automatic t_skip_rbit_R8;
    opa = 8'h20; sel = 3'd5; pol = 1'b1; next_two_word = 1'b1;
    issue(3'd5, 300); expect_out("R8 bit set two-word R10", 1, 303, 1, 3);
    pol = 1'b0;
    issue(3'd5, 300); expect_out("R8 bit clear test", 1, 301, 0, 1);
  endtask

  task automatic t_skip_io_R9;
    io_byte = 8'hFE; sel = 3'd0; pol = 1'b0; next_two_word = 1'b0;
    issue(3'd6, 400); expect_out("R9 io bit clear", 1, 402, 1, 2);
    pol = 1'b1;
    issue(3'd6, 400); expect_out("R9 io bit set test", 1, 401, 0, 1);
  endtask

  task automatic t_wrap_R11;
    opa = 8'h11; opb = 8'h11; next_two_word = 1'b1;
    issue(3'd4, 1022); expect_out("R11 skip wrap", 1, 1, 1, 3);
    issue(3'd0, 1023); expect_out("R11 seq wrap", 1, 0, 0, 1);
  endtask

  task automatic t_seq_R12;
    issue(3'd0, 77); expect_out("R12 class 0", 1, 78, 0, 1);
    issue(3'd7, 77); expect_out("R12 class 7", 1, 78, 0, 1);
  endtask

  task automatic t_hold_R2;
    disp = 12'd5; issue(3'd1, 10); expect_out("R2 issue", 1, 16, 1, 2);
    op_class = 3'd2; zptr = 16'h0123; pc = PC_W'(999);
    repeat (3) @(negedge clk);
    expect_out("R2 hold while idle", 0, 16, 1, 2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_R1();
    rst_n = 1'b1;
    @(negedge clk);
    t_reljmp_R3();
    t_indjmp_R4();
    t_branch_R5();
    t_signed_R6();
    t_skip_eq_R7();
    t_skip_rbit_R8();
    t_skip_io_R9();
    t_wrap_R11();
    t_seq_R12();
    t_hold_R2();
    report();
    $finish;
  end

endmodule